// File: doc/BRIEF.md
# Bidirectional Bit Scan Unit

This unit finds the position of a set bit in a 32-bit source word. A direction input picks the search order. A forward scan returns the lowest set bit. A reverse scan returns the highest set bit. In both directions the result is an unsigned position counted from bit 0.

A request is one cycle with `scan_valid` high. With it the caller presents the source word, the direction and the current destination value. On the next clock edge the unit registers three things: the position, a flag that says the source was empty, and a one-cycle completion strobe. When the source is empty, the position output takes the destination value that came with the request, so an empty scan leaves the destination as it was.

Both directions share one priority encoder. A reverse scan mirrors the word, encodes it, and converts the encoded position back into a count from bit 0.

Top module: `bitscan_unit`

## Requirements
- R1: With `scan_dir` = 0 (forward), `dest_idx` becomes the index of the lowest-numbered 1 bit of `src_word` on the clock edge after the request.
- R2: With `scan_dir` = 1 (reverse), `dest_idx` becomes the index of the highest-numbered 1 bit of `src_word` on the clock edge after the request.
- R3: The index is counted from bit 0 in both directions. A reverse scan of a word whose only set bit is bit 0 returns 0, and a forward scan of a word whose only set bit is bit 31 returns 31.
- R4: When a request's `src_word` is all zeros, `zero_flag` is 1 after the next edge.
- R5: When a request's `src_word` has at least one 1 bit, `zero_flag` is 0 after the next edge.
- R6: `done` is 1 in the cycle after each cycle in which `scan_valid` is 1, and 0 after every cycle in which `scan_valid` is 0.
- R7: For an all-zero source, `dest_idx` takes the `prev_dest` value presented with that same request.
- R8: In a cycle without `scan_valid`, `dest_idx` and `zero_flag` keep their values, whatever the other inputs carry.
- R9: While `rst_n` is 0, `dest_idx`, `zero_flag` and `done` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_valid | input | 1 | Request strobe |
| scan_dir | input | 1 | 0 = forward (lowest bit), 1 = reverse (highest bit) |
| src_word | input | 32 | Word to scan |
| prev_dest | input | 5 | Current destination value, kept when the source is empty |
| dest_idx | output | 5 | Registered bit position, or the kept destination |
| zero_flag | output | 1 | Registered: 1 when the scanned word was all zeros |
| done | output | 1 | One-cycle strobe after each request |

## Verification
Two functions can meet on one clock edge: a result being presented and the next request being captured. The bench sends requests on consecutive cycles, with a non-empty word followed by an empty word that carries a different `prev_dest`. The second result must show the new `prev_dest` with the zero flag set, and `done` must stay high across both cycles. This catches a design that keeps its own last result instead of the value supplied with the empty request. The bench also crosses the direction switch with single-bit words at both ends of the word, so a mirror or index-conversion error appears at bit 0 and at bit 31.

// File: rtl/bitscan_pkg.sv
// bitscan_pkg: shared constants and types for the bit scan unit.
// Assumes a power-of-two data width so the index fits exactly in IDX_W bits.
package bitscan_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = $clog2(DATA_W);

    // Scan order selected by the direction input.
    typedef enum logic {
        SCAN_FWD = 1'b0,
        SCAN_REV = 1'b1
    } scan_dir_e;
endpackage

// File: rtl/bitscan_mirror.sv
// bitscan_mirror: reverses the bit order of a word when enabled, else passes it through.
// Assumes W >= 1; purely combinational.
module bitscan_mirror #(
    parameter int W = 32
) (
    input  logic         flip,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] reversed;

    // Wire-only bit reversal, one connection per bit.
    for (genvar g = 0; g < W; g++) begin : g_rev
        assign reversed[g] = din[W-1-g];
    end

    // Select the mirrored or the straight word.
    always_comb begin
        dout = flip ? reversed : din;
    end
endmodule

// File: rtl/bitscan_lowenc.sv
// bitscan_lowenc: returns the index of the lowest set bit and an empty indication.
// Assumes W is a power of two; the index is 0 when the word is empty.
module bitscan_lowenc #(
    parameter int W   = 32,
    parameter int IW  = $clog2(W)
) (
    input  logic [W-1:0]  din,
    output logic [IW-1:0] pos,
    output logic          empty
);
    // Scan from the top down so the last hit is the lowest set bit.
    always_comb begin
        pos = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (din[i]) pos = IW'(i);
        end
        empty = (din == '0);
    end
endmodule

// File: rtl/bitscan_unit.sv
// bitscan_unit: one-cycle forward/reverse first-set-bit scan with a registered result.
// Assumes the caller supplies the current destination value in prev_dest for every request.
module bitscan_unit
    import bitscan_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int IW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scan_valid,
    input  logic          scan_dir,
    input  logic [W-1:0]  src_word,
    input  logic [IW-1:0] prev_dest,
    output logic [IW-1:0] dest_idx,
    output logic          zero_flag,
    output logic          done
);
    localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);

    logic          is_rev;
    logic [W-1:0]  scan_word;
    logic [IW-1:0] raw_pos;
    logic          word_empty;
    logic [IW-1:0] bit_pos;
    logic [IW-1:0] next_idx;

    // Decode the direction select into the mirror control.
    always_comb begin
        is_rev = (scan_dir_e'(scan_dir) == SCAN_REV);
    end

    bitscan_mirror #(.W(W)) u_mirror (
        .flip (is_rev),
        .din  (src_word),
        .dout (scan_word)
    );

    bitscan_lowenc #(.W(W), .IW(IW)) u_enc (
        .din   (scan_word),
        .pos   (raw_pos),
        .empty (word_empty)
    );

    // Convert the mirrored position back to a count from bit 0, and keep the destination when empty.
    always_comb begin
        bit_pos  = is_rev ? (TOP_IDX - raw_pos) : raw_pos;
        next_idx = word_empty ? prev_dest : bit_pos;
    end

    // Result register: load on a request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_idx  <= '0;
            zero_flag <= 1'b0;
        end else if (scan_valid) begin
            dest_idx  <= next_idx;
            zero_flag <= word_empty;
        end
    end

    // Completion strobe: one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= scan_valid;
    end
endmodule

// File: rtl/bitscan_unit_chk.sv
// bitscan_unit_chk: temporal checks on the bit scan unit ports, attached by bind.
module bitscan_unit_chk #(
    parameter int W  = 32,
    parameter int IW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scan_valid,
    input logic          scan_dir,
    input logic [W-1:0]  src_word,
    input logic [IW-1:0] prev_dest,
    input logic [IW-1:0] dest_idx,
    input logic          zero_flag,
    input logic          done
);
    a_r1_fwd_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !scan_dir && src_word[0]) |=> (dest_idx == '0));
    a_r2_rev_top: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && scan_dir && src_word[W-1]) |=> (dest_idx == IW'(W - 1)));
    a_r4_zero_set: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && src_word == '0) |=> zero_flag);
    a_r5_zero_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && src_word != '0) |=> !zero_flag);
    a_r6_done_after: assert property (@(posedge clk) disable iff (!rst_n)
        scan_valid |=> done);
    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_valid |=> !done);
    a_r7_keep_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && src_word == '0) |=> (dest_idx == $past(prev_dest)));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_valid |=> ($stable(dest_idx) && $stable(zero_flag)));
endmodule

bind bitscan_unit bitscan_unit_chk #(.W(W), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_valid (scan_valid),
    .scan_dir   (scan_dir),
    .src_word   (src_word),
    .prev_dest  (prev_dest),
    .dest_idx   (dest_idx),
    .zero_flag  (zero_flag),
    .done       (done)
);

// File: tb/bitscan_unit_tb.sv
module bitscan_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_valid = 1'b0;
    logic        scan_dir = 1'b0;
    logic [31:0] src_word = '0;
    logic [4:0]  prev_dest = '0;
    logic [4:0]  dest_idx;
    logic        zero_flag;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bitscan_unit u_dut (
        .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .scan_dir(scan_dir),
        .src_word(src_word), .prev_dest(prev_dest),
        .dest_idx(dest_idx), .zero_flag(zero_flag), .done(done)
    );

    // Arithmetic reference: lowest set bit, or highest set bit in reverse mode.
    function automatic logic [4:0] ref_idx(input logic [31:0] w, input logic dir, input logic [4:0] keep);
        logic [4:0] r;
        r = keep;
        if (dir) begin
            for (int i = 0; i < 32; i++) if (w[i]) r = 5'(i);
        end else begin
            for (int i = 31; i >= 0; i--) if (w[i]) r = 5'(i);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one request at a falling edge.
    task automatic drive(input logic [31:0] w, input logic dir, input logic [4:0] keep);
        scan_valid = 1'b1; src_word = w; scan_dir = dir; prev_dest = keep;
    endtask

    // Check the result of the request captured at the last rising edge.
    task automatic check_result(input string req, input logic [31:0] w, input logic dir, input logic [4:0] keep);
        check(req, 32'(dest_idx), 32'(ref_idx(w, dir, keep)));
        check(w == 0 ? "R4" : "R5", 32'(zero_flag), 32'(w == 0));
        check("R6", 32'(done), 32'd1);
    endtask

    task automatic one_scan(input string req, input logic [31:0] w, input logic dir, input logic [4:0] keep);
        @(negedge clk);
        drive(w, dir, keep);
        @(negedge clk);
        scan_valid = 1'b0;
        check_result(req, w, dir, keep);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset clears the outputs even when a request is presented during reset.
        scan_valid = 1'b1; src_word = 32'h8000_0000; scan_dir = 1'b1; prev_dest = 5'd7;
        repeat (3) @(negedge clk);
        check("R9", 32'(dest_idx), 0);
        check("R9", 32'(zero_flag), 0);
        check("R9", 32'(done), 0);
        scan_valid = 1'b0;
        rst_n = 1'b1;

        // R1, R2, R3: every single-bit word in both directions.
        for (int b = 0; b < 32; b++) begin
            one_scan("R1", 32'd1 << b, 1'b0, 5'd0);
            one_scan("R2", 32'd1 << b, 1'b1, 5'd0);
        end
        // R3: end positions keep their absolute index.
        one_scan("R3", 32'h0000_0001, 1'b1, 5'd9);
        one_scan("R3", 32'h8000_0000, 1'b0, 5'd9);

        // R4, R7: all-zero word in both directions keeps the supplied destination.
        one_scan("R7", 32'h0, 1'b0, 5'd19);
        one_scan("R7", 32'h0, 1'b1, 5'd31);

        // R1, R2: random words, dense and sparse.
        for (int n = 0; n < 300; n++) begin
            logic [31:0] w;
            w = $urandom;
            if (n % 2 == 1) w = w & $urandom & $urandom;
            one_scan("R1", w, 1'b0, 5'($urandom));
            one_scan("R2", w, 1'b1, 5'($urandom));
        end

        // R6: done falls after an idle cycle.
        @(negedge clk);
        check("R6", 32'(done), 0);

        // R8: inputs change without a request; the result holds.
        begin
            logic [4:0] held_idx;
            logic       held_z;
            held_idx = dest_idx; held_z = zero_flag;
            src_word = 32'h0; scan_dir = 1'b1; prev_dest = ~held_idx;
            @(negedge clk);
            check("R8", 32'(dest_idx), 32'(held_idx));
            check("R8", 32'(zero_flag), 32'(held_z));
        end

        // R7 with R6: back-to-back requests, a non-empty word then an empty one.
        @(negedge clk);
        drive(32'h0001_0100, 1'b1, 5'd3);
        @(negedge clk);
        check_result("R2", 32'h0001_0100, 1'b1, 5'd3);
        drive(32'h0, 1'b0, 5'd27);
        @(negedge clk);
        check_result("R7", 32'h0, 1'b0, 5'd27);
        drive(32'h0001_0100, 1'b0, 5'd27);
        @(negedge clk);
        scan_valid = 1'b0;
        check_result("R1", 32'h0001_0100, 1'b0, 5'd27);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule